// File: doc/BRIEF.md
# Dual-Channel DAC Power-State Controller

This block holds the power state of two DAC output channels and of the bias generator they share. A serial front end, not part of this block, decodes each command word and hands over single-cycle strobes. There is one strobe per channel for a DAC-register write and one per channel for a single-channel shutdown. Two more strobes shut down both channels at once: one keeps the bias running and the other also turns the bias off (full power-down). A per-channel termination bit travels with every shutdown command.

For each channel the block drives three outputs: an enable, the selected shutdown load, and an output-valid flag. The valid flag models the analog settling time after the channel wakes. It is held low by a cycle counter whose length depends on the wake-up case. Waking from a plain channel shutdown gives the short delay. Waking after a full power-down, or after reset, gives the long delay. Shutting a channel down clears its flag in the next cycle. All pins are plain level or strobe signals and have no handshake: every strobe acts in the cycle it is high.

Settling times are given in microseconds and converted to cycles by the `CYC_PER_US` parameter. The `HIGH_SUPPLY` parameter chooses the pair of times for the higher-voltage variant.

Top module: `dac_pwr_ctrl`

## Requirements
- R1: After reset the bias is on and both channels are enabled with termination 1. Each channel's valid flag stays low until exactly FULL_CYC clock edges have passed after reset release, and is high from then on.
- R2: A DAC-register write to a shut-down channel enables only that channel, from the next cycle. The other channel keeps its state.
- R3: A DAC-register write while the bias is off turns the bias on in the next cycle, and the woken channel waits FULL_CYC cycles before its valid flag rises.
- R4: A DAC-register write to a shut-down channel while the bias is on starts a wait of DAC_CYC cycles. Valid rises exactly DAC_CYC cycles after the enable rises.
- R5: A single-channel shutdown clears that channel's enable and valid flag in the next cycle and leaves the bias and the other channel unchanged.
- R6: Every shutdown command (single, both, full) loads each affected channel's termination output from term_i of that channel: 0 selects the low-ohm load (about 1 kΩ to ground), 1 selects the high-ohm load (about 200 kΩ). Without a shutdown command the termination holds.
- R7: The shut-down-both command turns both channels off and never changes the bias. If it arrives during full power-down, the bias stays off.
- R8: Full power-down turns off the bias and both channels in the next cycle.
- R9: A DAC-register write to a channel that is already enabled changes neither its enable nor its settling count or valid flag.
- R10: When strobes coincide in one cycle, full power-down wins over shut-down-both, which wins over a single-channel shutdown, which wins over a DAC-register write for that channel.
- R11: HIGH_SUPPLY=0 gives DAC_CYC = 50·CYC_PER_US and FULL_CYC = 60·CYC_PER_US. HIGH_SUPPLY=1 gives 60·CYC_PER_US and 70·CYC_PER_US.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| upd_i | input | 2 | DAC-register write strobe per channel (bit 0 = channel A) |
| shdn_i | input | 2 | Single-channel shutdown strobe per channel |
| shdn_all_i | input | 1 | Shut down both channels, bias untouched |
| full_pd_i | input | 1 | Shut down both channels and the bias |
| term_i | input | 2 | Termination bit per channel, used with any shutdown strobe |
| ch_en_o | output | 2 | Channel output amplifier enabled |
| ch_term_o | output | 2 | Shutdown load select: 0 low-ohm, 1 high-ohm |
| ch_valid_o | output | 2 | Channel enabled and settled |
| bias_en_o | output | 1 | Shared bias generator enabled |

## Verification
The power sequences are first run one at a time: reset settling, full power-down followed by a redundant shut-down-both, a single-channel wake from full power-down, a wake with the bias already on, a repeated write to a live channel, and a single-channel shutdown. These separate the short settling delay from the long one and separate bias control from channel control. One cycle puts full power-down and a write on the same channel at once, to pin down the priority. Long stretches of sparse random strobes with random termination bits then mix shutdowns into settling windows that are still running. Every output is compared each cycle with a reference model built from the requirements. A second instance with the higher-supply setting checks the other settling pair after reset.

// File: rtl/dac_pwr_pkg.sv
package dac_pwr_pkg;
  localparam int NCH = 2;

  typedef struct packed {
    logic en;
    logic term;
    logic valid;
  } ch_stat_t;

  function automatic int us_to_cyc(input int us, input int cyc_per_us);
    return us * cyc_per_us;
  endfunction
endpackage

// File: rtl/dac_bias_ctrl.sv
module dac_bias_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic kill_i,
  input  logic wake_i,
  output logic bias_o
);
  always_ff @(posedge clk) begin
    if (!rst_n)      bias_o <= 1'b1;
    else if (kill_i) bias_o <= 1'b0;
    else if (wake_i) bias_o <= 1'b1;
  end
endmodule

// File: rtl/dac_chan_pwr.sv
module dac_chan_pwr #(
  parameter int DAC_CYC  = 100,
  parameter int FULL_CYC = 120,
  localparam int CW = $clog2(FULL_CYC + 1)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  sleep_i,
  input  logic                  wake_i,
  input  logic                  term_i,
  input  logic                  bias_on_i,
  output dac_pwr_pkg::ch_stat_t stat_o
);
  logic          en_q, term_q;
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q   <= 1'b1;
      term_q <= 1'b1;
      cnt_q  <= CW'(FULL_CYC);
    end else if (sleep_i) begin
      en_q   <= 1'b0;
      term_q <= term_i;
      cnt_q  <= '0;
    end else if (wake_i && !en_q) begin
      en_q  <= 1'b1;
      cnt_q <= bias_on_i ? CW'(DAC_CYC) : CW'(FULL_CYC);
    end else if (en_q && cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  always_comb begin
    stat_o.en    = en_q;
    stat_o.term  = term_q;
    stat_o.valid = en_q && (cnt_q == '0);
  end
endmodule

// File: rtl/dac_pwr_ctrl.sv
module dac_pwr_ctrl #(
  parameter int CYC_PER_US  = 125,
  parameter bit HIGH_SUPPLY = 1'b0
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [dac_pwr_pkg::NCH-1:0] upd_i,
  input  logic [dac_pwr_pkg::NCH-1:0] shdn_i,
  input  logic                       shdn_all_i,
  input  logic                       full_pd_i,
  input  logic [dac_pwr_pkg::NCH-1:0] term_i,
  output logic [dac_pwr_pkg::NCH-1:0] ch_en_o,
  output logic [dac_pwr_pkg::NCH-1:0] ch_term_o,
  output logic [dac_pwr_pkg::NCH-1:0] ch_valid_o,
  output logic                       bias_en_o
);
  import dac_pwr_pkg::*;

  localparam int DAC_US   = HIGH_SUPPLY ? 60 : 50;
  localparam int FULL_US  = HIGH_SUPPLY ? 70 : 60;
  localparam int DAC_CYC  = us_to_cyc(DAC_US, CYC_PER_US);
  localparam int FULL_CYC = us_to_cyc(FULL_US, CYC_PER_US);

  logic [NCH-1:0] sleep, wake;
  ch_stat_t       stat [NCH];

  dac_bias_ctrl u_bias (
    .clk    (clk),
    .rst_n  (rst_n),
    .kill_i (full_pd_i),
    .wake_i (|wake),
    .bias_o (bias_en_o)
  );

  for (genvar k = 0; k < NCH; k++) begin : g_ch
    assign sleep[k] = full_pd_i | shdn_all_i | shdn_i[k];
    assign wake[k]  = upd_i[k] & ~sleep[k];

    dac_chan_pwr #(.DAC_CYC(DAC_CYC), .FULL_CYC(FULL_CYC)) u_ch (
      .clk       (clk),
      .rst_n     (rst_n),
      .sleep_i   (sleep[k]),
      .wake_i    (wake[k]),
      .term_i    (term_i[k]),
      .bias_on_i (bias_en_o),
      .stat_o    (stat[k])
    );

    assign ch_en_o[k]    = stat[k].en;
    assign ch_term_o[k]  = stat[k].term;
    assign ch_valid_o[k] = stat[k].valid;
  end
endmodule

// File: rtl/dac_pwr_ctrl_chk.sv
module dac_pwr_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [1:0] upd_i,
  input logic [1:0] shdn_i,
  input logic       shdn_all_i,
  input logic       full_pd_i,
  input logic [1:0] term_i,
  input logic [1:0] ch_en_o,
  input logic [1:0] ch_term_o,
  input logic [1:0] ch_valid_o,
  input logic       bias_en_o
);
  for (genvar k = 0; k < 2; k++) begin : g_a
    AST_SLEEP_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      (shdn_i[k] | shdn_all_i | full_pd_i) |=> (!ch_en_o[k] && !ch_valid_o[k])); // R5
    AST_WAKE_SETS: assert property (@(posedge clk) disable iff (!rst_n)
      (upd_i[k] && !(shdn_i[k] | shdn_all_i | full_pd_i)) |=> (ch_en_o[k] && bias_en_o)); // R2
    AST_TERM_LOADED: assert property (@(posedge clk) disable iff (!rst_n)
      (shdn_i[k] | shdn_all_i | full_pd_i) |=> (ch_term_o[k] == $past(term_i[k]))); // R6
    AST_TERM_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      !(shdn_i[k] | shdn_all_i | full_pd_i) |=> $stable(ch_term_o[k])); // R6
    AST_VALID_NEEDS_BIAS: assert property (@(posedge clk) disable iff (!rst_n)
      ch_valid_o[k] |-> bias_en_o); // R3
    AST_VALID_AFTER_EN: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ch_valid_o[k]) |-> $past(ch_en_o[k])); // R4
  end

  AST_FULLPD_BIAS_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    full_pd_i |=> !bias_en_o); // R8
  AST_BOTH_KEEPS_BIAS: assert property (@(posedge clk) disable iff (!rst_n)
    (shdn_all_i && !full_pd_i) |=> (bias_en_o == $past(bias_en_o))); // R7
endmodule

bind dac_pwr_ctrl dac_pwr_ctrl_chk chk_i (
  .clk(clk), .rst_n(rst_n), .upd_i(upd_i), .shdn_i(shdn_i),
  .shdn_all_i(shdn_all_i), .full_pd_i(full_pd_i), .term_i(term_i),
  .ch_en_o(ch_en_o), .ch_term_o(ch_term_o), .ch_valid_o(ch_valid_o),
  .bias_en_o(bias_en_o)
);

// File: tb/dac_pwr_ctrl_tb.sv
module dac_pwr_ctrl_tb_top;
  localparam int CPU     = 2;
  localparam int DAC_LO  = 50 * CPU;
  localparam int FULL_LO = 60 * CPU;
  localparam int FULL_HI = 70 * CPU;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] upd = '0, shdn = '0, term = '0;
  logic       sall = 1'b0, fpd = 1'b0;
  logic [1:0] en, trm, vld, en_h, trm_h, vld_h;
  logic       bias, bias_h;

  int errors = 0, checks = 0;
  bit done = 1'b0;
  string tag = "R1";

  // reference model
  logic       m_bias;
  logic [1:0] m_en, m_term;
  int         m_cnt [2];

  always #4 clk = ~clk;

  dac_pwr_ctrl #(.CYC_PER_US(CPU), .HIGH_SUPPLY(1'b0)) dut_i (
    .clk(clk), .rst_n(rst_n), .upd_i(upd), .shdn_i(shdn), .shdn_all_i(sall),
    .full_pd_i(fpd), .term_i(term), .ch_en_o(en), .ch_term_o(trm),
    .ch_valid_o(vld), .bias_en_o(bias));

  dac_pwr_ctrl #(.CYC_PER_US(CPU), .HIGH_SUPPLY(1'b1)) dut_hi (
    .clk(clk), .rst_n(rst_n), .upd_i(2'b00), .shdn_i(2'b00), .shdn_all_i(1'b0),
    .full_pd_i(1'b0), .term_i(2'b00), .ch_en_o(en_h), .ch_term_o(trm_h),
    .ch_valid_o(vld_h), .bias_en_o(bias_h));

  function automatic logic [1:0] m_valid();
    logic [1:0] v;
    for (int k = 0; k < 2; k++) v[k] = m_en[k] && (m_cnt[k] == 0);
    return v;
  endfunction

  function automatic logic [6:0] m_pack();
    return {m_bias, m_en, m_term, m_valid()};
  endfunction

  task automatic model_reset();
    m_bias = 1'b1; m_en = 2'b11; m_term = 2'b11;
    m_cnt[0] = FULL_LO; m_cnt[1] = FULL_LO;
  endtask

  task automatic model_step();
    logic nb;
    logic [1:0] slp, wk;
    for (int k = 0; k < 2; k++) begin
      slp[k] = fpd | sall | shdn[k];
      wk[k]  = upd[k] & ~slp[k];
    end
    nb = fpd ? 1'b0 : ((|wk) ? 1'b1 : m_bias);
    for (int k = 0; k < 2; k++) begin
      if (slp[k]) begin
        m_en[k] = 1'b0; m_term[k] = term[k]; m_cnt[k] = 0;
      end else if (wk[k] && !m_en[k]) begin
        m_en[k] = 1'b1; m_cnt[k] = m_bias ? DAC_LO : FULL_LO;
      end else if (m_en[k] && m_cnt[k] > 0) begin
        m_cnt[k] = m_cnt[k] - 1;
      end
    end
    m_bias = nb;
  endtask

  task automatic check_all();
    logic [6:0] act, exp;
    act = {bias, en, trm, vld};
    exp = m_pack();
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: {bias,en,term,valid} actual=%b expected=%b at %0t", tag, act, exp, $time);
    end
  endtask

  // one cycle: inputs already driven; edge, model, check at negedge, clear strobes
  task automatic cycle();
    @(posedge clk);
    model_step();
    @(negedge clk);
    check_all();
    upd = '0; shdn = '0; sall = 1'b0; fpd = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) cycle();
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    #(8 * 150000);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    void'($urandom(32'h5eed_0731));
    model_reset();
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state and long settling on both channels
    tag = "R1";
    check_all();
    idle(FULL_LO + 5);
    // R11 high-supply instance: valid after exactly FULL_HI edges
    tag = "R11";
    idle(FULL_HI - FULL_LO - 6);
    checks++;
    if (vld_h !== 2'b00) begin
      errors++; $display("FAIL R11: valid actual=%b expected=00", vld_h);
    end
    idle(1);
    checks++;
    if (vld_h !== 2'b11) begin
      errors++; $display("FAIL R11: valid actual=%b expected=11", vld_h);
    end
    // R8 full power-down with per-channel terms (R6)
    tag = "R8"; fpd = 1'b1; term = 2'b01; cycle();
    idle(3);
    // R7 shut down both during full power-down: bias stays off
    tag = "R7"; sall = 1'b1; term = 2'b10; cycle();
    idle(3);
    // R3 wake channel A from full power-down; B stays off (R2)
    tag = "R3"; upd = 2'b01; cycle();
    idle(FULL_LO + 4);
    // R7 shut down both with bias on: bias holds
    tag = "R7"; sall = 1'b1; term = 2'b01; cycle();
    idle(2);
    // R4 wake B with bias on: short delay
    tag = "R4"; upd = 2'b10; cycle();
    idle(DAC_LO + 4);
    // R9 write to live channel B
    tag = "R9"; upd = 2'b10; cycle();
    idle(4);
    // R5 single shutdown of B; A unaffected
    tag = "R5"; upd = 2'b01; cycle(); idle(10);
    shdn = 2'b10; term = 2'b00; cycle();
    idle(5);
    // R6 termination holds without shutdown
    tag = "R6"; term = 2'b11; idle(5);
    // R10 priorities in the same cycle
    tag = "R10"; fpd = 1'b1; sall = 1'b1; upd = 2'b11; term = 2'b10; cycle();
    idle(2);
    upd = 2'b11; shdn = 2'b01; term = 2'b11; cycle();
    idle(FULL_LO + 3);
    sall = 1'b1; upd = 2'b11; term = 2'b00; cycle();
    idle(3);
    // R2 random mix
    tag = "R2";
    for (int i = 0; i < 6000; i++) begin
      for (int k = 0; k < 2; k++) begin
        upd[k]  = ($urandom % 40) == 0;
        shdn[k] = ($urandom % 90) == 0;
      end
      sall = ($urandom % 200) == 0;
      fpd  = ($urandom % 260) == 0;
      term = 2'($urandom);
      cycle();
    end
    finish_run();
  end
endmodule